// File: doc/BRIEF.md
# Static-Column DRAM Controller with Row-Only Refresh

This block connects a simple synchronous request port to a 64K x 4 dynamic memory with a multiplexed address bus. A requester presents a 16-bit word address, a read/write flag and 4 bits of write data under a valid/ready handshake. Read data comes back on a separate response strobe. On the memory side the controller drives active-low row strobe, column strobe and write enable. It places the row or the column on 8 shared address lines and controls split data-out, data-in and output-enable lines for the bidirectional data pins.

An opened row stays open after an access. A later access to the same row in the same direction skips the row phase. For reads, the column strobe stays low across the page and only the column address moves. An access to another row, or a change between reading and writing, closes the page and waits out a precharge time. A free-running timer requests a refresh at a fixed period. The refresh is a row-only cycle on an 8-bit wrapping row counter. A pending refresh is served at the next idle point, and an idle open page is closed first. Every timing window is a parameter counted in clocks.

Top module: `scdram_ctrl`

## Requirements
- R1: While reset is asserted, row strobe, column strobe and write enable are high, the data drivers are off, and no response is signalled.
- R2: A row opens in three phases. First comes one cycle with the row (address bits 15:8) on the address lines and the row strobe high. Then the row strobe is low for T_RAH cycles with the row still on the lines. Only after that does the column (address bits 7:0) appear.
- R3: A read holds the column with the column strobe low and write enable high for T_CAC cycles. The data-in lines are sampled in the last of these cycles and returned on rspData in the next cycle, with rspValid high for exactly that one cycle.
- R4: A write first spends one cycle with the column on the lines, write enable low, the column strobe high and the data driven. The column strobe is then low for T_WP cycles. Column strobe, write enable and the data drivers are released at the same edge.
- R5: A read to the open row after a read is accepted without a new row phase. The column strobe stays low between accesses, and only the column address changes.
- R6: With the page open, a request to a different row or in the other direction is held off (ready low). The row strobe then goes high for T_RP cycles, and there is at least one idle cycle before the next row opens.
- R7: A refresh becomes pending every REF_PERIOD clocks, counted from the end of reset.
- R8: A refresh puts the refresh row on the lines for one cycle with the row strobe high. The row strobe is then low for T_REF_RAS cycles with the column strobe high throughout, and a T_RP precharge follows.
- R9: A pending refresh is taken before any new request when the page is closed. It closes an open page that has no request being accepted.
- R10: The refresh row starts at 0, advances by one after each refresh and wraps from 255 to 0.
- R11: The data drivers are enabled only in write cycles, always with write enable low and the row strobe low.
- R12: reqReady is high whenever the page is closed, the controller is idle and no refresh is pending. With the page open, it is high only for a same-row, same-direction request while no refresh is pending. It is low in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Request taken this cycle when high together with reqValid |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 2*MUX_W | Word address, row in upper half, column in lower half |
| reqWdata | input | DATA_W | Write data |
| rspValid | output | 1 | Read data valid, one cycle per read |
| rspData | output | DATA_W | Read data |
| dramA | output | MUX_W | Multiplexed row/column address |
| dramRasN | output | 1 | Row strobe, active low |
| dramCasN | output | 1 | Column strobe, active low |
| dramWeN | output | 1 | Write enable, active low |
| dramDqOut | output | DATA_W | Data toward the memory |
| dramDqOe | output | 1 | Enable for the data drivers |
| dramDqIn | input | DATA_W | Data from the memory |

## Verification
The bench builds the controller with T_RAH=2, T_CAC=3, T_WP=2, T_RP=2 and T_REF_RAS=3. Each hold window then lasts more than one cycle, so an off-by-one in any counter shifts a pin edge that the per-clock reference model sees. REF_PERIOD is cut to 50 clocks. This brings several hundred refreshes, and so the 255-to-0 wrap of the refresh row, into a run of about fifteen thousand cycles. It also makes refreshes collide often with open pages and with queued page-miss requests.

// File: rtl/scdram_pkg.sv
package scdram_pkg;

  typedef enum logic [1:0] {
    SEL_ROW,
    SEL_COL,
    SEL_REF
  } addrSel_e;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ROWSET,
    ST_RAH,
    ST_RD,
    ST_WSET,
    ST_WR,
    ST_PAGE,
    ST_PRE,
    ST_REFSET,
    ST_REFRAS
  } state_e;

  // Strobes from control to datapath plus the decoded memory pins
  typedef struct packed {
    logic     latchReq;
    logic     latchRead;
    logic     refDone;
    addrSel_e addrSel;
    logic     rasN;
    logic     casN;
    logic     weN;
    logic     dqOe;
  } strobe_t;

endpackage

// File: rtl/scdram_reftimer.sv
module scdram_reftimer #(
  parameter int REF_PERIOD = 780
) (
  input  logic clk,
  input  logic rst_n,
  input  logic refTake,
  output logic refPending
);
  localparam int RC_W = (REF_PERIOD < 2) ? 1 : $clog2(REF_PERIOD);
  localparam logic [RC_W-1:0] LAST = RC_W'(REF_PERIOD - 1);

  logic [RC_W-1:0] refCnt;
  logic            tick;

  assign tick = (refCnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      refCnt     <= '0;
      refPending <= 1'b0;
    end else begin
      refCnt <= tick ? '0 : refCnt + RC_W'(1);
      if (tick)         refPending <= 1'b1;
      else if (refTake) refPending <= 1'b0;
    end
  end
endmodule

// File: rtl/scdram_fsm.sv
module scdram_fsm
  import scdram_pkg::*;
#(
  parameter int T_RAH     = 1,
  parameter int T_CAC     = 4,
  parameter int T_WP      = 2,
  parameter int T_RP      = 3,
  parameter int T_REF_RAS = 4
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    reqValid,
  input  logic    reqWrite,
  input  logic    rowHit,
  input  logic    refPending,
  output logic    reqReady,
  output logic    refTake,
  output strobe_t stb
);
  localparam int M1    = (T_RAH > T_CAC) ? T_RAH : T_CAC;
  localparam int M2    = (M1 > T_WP) ? M1 : T_WP;
  localparam int M3    = (M2 > T_RP) ? M2 : T_RP;
  localparam int T_MAX = (M3 > T_REF_RAS) ? M3 : T_REF_RAS;
  localparam int CNT_W = (T_MAX < 2) ? 1 : $clog2(T_MAX);

  localparam logic [CNT_W-1:0] LD_RAH = CNT_W'(T_RAH - 1);
  localparam logic [CNT_W-1:0] LD_CAC = CNT_W'(T_CAC - 1);
  localparam logic [CNT_W-1:0] LD_WP  = CNT_W'(T_WP - 1);
  localparam logic [CNT_W-1:0] LD_RP  = CNT_W'(T_RP - 1);
  localparam logic [CNT_W-1:0] LD_REF = CNT_W'(T_REF_RAS - 1);

  state_e           state, stateNxt;
  logic [CNT_W-1:0] cnt, cntNxt;
  logic             pageWrite, pageWriteNxt;
  logic             cntDone;

  assign cntDone = (cnt == '0);

  always_comb begin
    stateNxt      = state;
    cntNxt        = cntDone ? cnt : cnt - CNT_W'(1);
    pageWriteNxt  = pageWrite;
    reqReady      = 1'b0;
    refTake       = 1'b0;
    stb.latchReq  = 1'b0;
    stb.latchRead = 1'b0;
    stb.refDone   = 1'b0;
    stb.addrSel   = SEL_ROW;
    stb.rasN      = 1'b1;
    stb.casN      = 1'b1;
    stb.weN       = 1'b1;
    stb.dqOe      = 1'b0;
    case (state)
      ST_IDLE: begin
        reqReady = !refPending;
        if (refPending) begin
          refTake  = 1'b1;
          stateNxt = ST_REFSET;
        end else if (reqValid) begin
          stb.latchReq = 1'b1;
          pageWriteNxt = reqWrite;
          stateNxt     = ST_ROWSET;
        end
      end
      ST_ROWSET: begin
        stateNxt = ST_RAH;
        cntNxt   = LD_RAH;
      end
      ST_RAH: begin
        stb.rasN = 1'b0;
        if (cntDone) begin
          stateNxt = pageWrite ? ST_WSET : ST_RD;
          cntNxt   = LD_CAC;
        end
      end
      ST_RD: begin
        stb.rasN    = 1'b0;
        stb.casN    = 1'b0;
        stb.addrSel = SEL_COL;
        if (cntDone) begin
          stb.latchRead = 1'b1;
          stateNxt      = ST_PAGE;
        end
      end
      ST_WSET: begin
        stb.rasN    = 1'b0;
        stb.weN     = 1'b0;
        stb.dqOe    = 1'b1;
        stb.addrSel = SEL_COL;
        stateNxt    = ST_WR;
        cntNxt      = LD_WP;
      end
      ST_WR: begin
        stb.rasN    = 1'b0;
        stb.casN    = 1'b0;
        stb.weN     = 1'b0;
        stb.dqOe    = 1'b1;
        stb.addrSel = SEL_COL;
        if (cntDone) stateNxt = ST_PAGE;
      end
      ST_PAGE: begin
        stb.rasN    = 1'b0;
        stb.casN    = pageWrite;
        stb.addrSel = SEL_COL;
        if (refPending) begin
          stateNxt = ST_PRE;
          cntNxt   = LD_RP;
        end else if (reqValid) begin
          if (rowHit && (reqWrite == pageWrite)) begin
            reqReady     = 1'b1;
            stb.latchReq = 1'b1;
            stateNxt     = reqWrite ? ST_WSET : ST_RD;
            cntNxt       = LD_CAC;
          end else begin
            stateNxt = ST_PRE;
            cntNxt   = LD_RP;
          end
        end
      end
      ST_PRE: begin
        if (cntDone) stateNxt = ST_IDLE;
      end
      ST_REFSET: begin
        stb.addrSel = SEL_REF;
        stateNxt    = ST_REFRAS;
        cntNxt      = LD_REF;
      end
      ST_REFRAS: begin
        stb.rasN    = 1'b0;
        stb.addrSel = SEL_REF;
        if (cntDone) begin
          stb.refDone = 1'b1;
          stateNxt    = ST_PRE;
          cntNxt      = LD_RP;
        end
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      pageWrite <= 1'b0;
    end else begin
      state     <= stateNxt;
      cnt       <= cntNxt;
      pageWrite <= pageWriteNxt;
    end
  end
endmodule

// File: rtl/scdram_datapath.sv
module scdram_datapath
  import scdram_pkg::*;
#(
  parameter int MUX_W  = 8,
  parameter int DATA_W = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  strobe_t              stb,
  input  logic [2*MUX_W-1:0]   reqAddr,
  input  logic [DATA_W-1:0]    reqWdata,
  input  logic [DATA_W-1:0]    dramDqIn,
  output logic                 rowHit,
  output logic [MUX_W-1:0]     dramA,
  output logic [DATA_W-1:0]    dramDqOut,
  output logic                 rspValid,
  output logic [DATA_W-1:0]    rspData
);
  logic [MUX_W-1:0]  rowReg, colReg, refRow;
  logic [DATA_W-1:0] wdataReg;

  assign rowHit    = (reqAddr[2*MUX_W-1:MUX_W] == rowReg);
  assign dramDqOut = wdataReg;

  always_comb begin
    case (stb.addrSel)
      SEL_COL: dramA = colReg;
      SEL_REF: dramA = refRow;
      default: dramA = rowReg;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rowReg   <= '0;
      colReg   <= '0;
      refRow   <= '0;
      wdataReg <= '0;
      rspValid <= 1'b0;
      rspData  <= '0;
    end else begin
      if (stb.latchReq) begin
        rowReg   <= reqAddr[2*MUX_W-1:MUX_W];
        colReg   <= reqAddr[MUX_W-1:0];
        wdataReg <= reqWdata;
      end
      if (stb.refDone) refRow <= refRow + MUX_W'(1);
      rspValid <= stb.latchRead;
      if (stb.latchRead) rspData <= dramDqIn;
    end
  end
endmodule

// File: rtl/scdram_ctrl.sv
module scdram_ctrl
  import scdram_pkg::*;
#(
  parameter int MUX_W      = 8,
  parameter int DATA_W     = 4,
  parameter int T_RAH      = 1,
  parameter int T_CAC      = 4,
  parameter int T_WP       = 2,
  parameter int T_RP       = 3,
  parameter int T_REF_RAS  = 4,
  parameter int REF_PERIOD = 780
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reqValid,
  output logic                reqReady,
  input  logic                reqWrite,
  input  logic [2*MUX_W-1:0]  reqAddr,
  input  logic [DATA_W-1:0]   reqWdata,
  output logic                rspValid,
  output logic [DATA_W-1:0]   rspData,
  output logic [MUX_W-1:0]    dramA,
  output logic                dramRasN,
  output logic                dramCasN,
  output logic                dramWeN,
  output logic [DATA_W-1:0]   dramDqOut,
  output logic                dramDqOe,
  input  logic [DATA_W-1:0]   dramDqIn
);
  strobe_t stb;
  logic    rowHit, refPending, refTake;

  scdram_reftimer #(.REF_PERIOD(REF_PERIOD)) u_timer (
    .clk(clk), .rst_n(rst_n), .refTake(refTake), .refPending(refPending)
  );

  scdram_fsm #(
    .T_RAH(T_RAH), .T_CAC(T_CAC), .T_WP(T_WP), .T_RP(T_RP), .T_REF_RAS(T_REF_RAS)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqWrite(reqWrite),
    .rowHit(rowHit), .refPending(refPending), .reqReady(reqReady),
    .refTake(refTake), .stb(stb)
  );

  scdram_datapath #(.MUX_W(MUX_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .stb(stb), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .dramDqIn(dramDqIn), .rowHit(rowHit), .dramA(dramA), .dramDqOut(dramDqOut),
    .rspValid(rspValid), .rspData(rspData)
  );

  assign dramRasN = stb.rasN;
  assign dramCasN = stb.casN;
  assign dramWeN  = stb.weN;
  assign dramDqOe = stb.dqOe;
endmodule

// File: rtl/scdram_checker.sv
module scdram_checker #(
  parameter int MUX_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rasN,
  input logic             casN,
  input logic             weN,
  input logic             dqOe,
  input logic             rspValid,
  input logic [MUX_W-1:0] dramA
);
  // R2: the address lines are not moving when the row strobe falls
  a_r2_row_stable: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rasN) |-> $stable(dramA));

  // R3: the column strobe is only ever low inside an open row
  a_r3_cas_inside_ras: assert property (@(posedge clk) disable iff (!rst_n)
    !casN |-> !rasN);

  // R3: one response pulse per read
  a_r3_rsp_single: assert property (@(posedge clk) disable iff (!rst_n)
    rspValid |=> !rspValid);

  // R4: write enable already low in the cycle before the column strobe falls on a write
  a_r4_we_before_cas: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(casN) && !weN) |-> $past(!weN));

  // R6: a rising row strobe stays high for more than one cycle
  a_r6_precharge: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rasN) |=> rasN);

  // R11: data drivers only during a write inside an open row
  a_r11_drive_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    dqOe |-> (!weN && !rasN));
endmodule

bind scdram_ctrl scdram_checker #(.MUX_W(MUX_W)) u_check (
  .clk(clk), .rst_n(rst_n), .rasN(dramRasN), .casN(dramCasN), .weN(dramWeN),
  .dqOe(dramDqOe), .rspValid(rspValid), .dramA(dramA)
);

// File: tb/tb_scdram_ctrl.sv
module tb_scdram_ctrl;
  localparam int MUX_W = 8, DATA_W = 4;
  localparam int T_RAH = 2, T_CAC = 3, T_WP = 2, T_RP = 2, T_REF_RAS = 3, REF_PERIOD = 50;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reqValid = 1'b0, reqWrite = 1'b0;
  logic [15:0] reqAddr = '0;
  logic [3:0]  reqWdata = '0;
  logic reqReady, rspValid, dramRasN, dramCasN, dramWeN, dramDqOe;
  logic [3:0] rspData, dramDqOut, dramDqIn;
  logic [7:0] dramA;

  always #10 clk = ~clk;

  scdram_ctrl #(
    .MUX_W(MUX_W), .DATA_W(DATA_W), .T_RAH(T_RAH), .T_CAC(T_CAC), .T_WP(T_WP),
    .T_RP(T_RP), .T_REF_RAS(T_REF_RAS), .REF_PERIOD(REF_PERIOD)
  ) dut (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .rspValid(rspValid), .rspData(rspData), .dramA(dramA), .dramRasN(dramRasN),
    .dramCasN(dramCasN), .dramWeN(dramWeN), .dramDqOut(dramDqOut),
    .dramDqOe(dramDqOe), .dramDqIn(dramDqIn)
  );

  function automatic logic [3:0] seedVal(logic [15:0] a);
    return a[3:0] ^ a[11:8] ^ a[15:12] ^ 4'h5;
  endfunction

  // Memory device model
  logic [3:0] mem [0:65535];
  logic [3:0] expMem [0:65535];
  logic [7:0] devRow = '0;
  initial for (int i = 0; i < 65536; i++) begin
    mem[i] = seedVal(16'(i));
    expMem[i] = seedVal(16'(i));
  end
  always @(negedge dramRasN) devRow = dramA;
  always @(negedge dramCasN) if (!dramRasN && !dramWeN) mem[{devRow, dramA}] = dramDqOut;
  always @* dramDqIn = (!dramRasN && !dramCasN && dramWeN) ? mem[{devRow, dramA}] : 4'h0;

  // Counters and check helper
  int nChecks = 0, nFail = 0;
  bit finished = 0;

  function automatic string tagName(int t);
    case (t)
      1: return "R1";   2: return "R2";   3: return "R3";   4: return "R4";
      5: return "R5";   6: return "R6";   7: return "R7";   8: return "R8";
      9: return "R9";  10: return "R10"; 11: return "R11"; 12: return "R12";
      default: return "R?";
    endcase
  endfunction

  task automatic chk(int tag, string what, logic [15:0] act, logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s at %0t: actual %h expected %h", tagName(tag), what, $time, act, exp);
    end
  endtask

  // Reference model: queue of expected pin states for committed cycles
  typedef struct {
    bit ras; bit cas; bit we; bit oe;
    logic [7:0] addr; logic [3:0] dq;
    bit rsp; logic [3:0] rdat; int tag;
  } pin_t;
  pin_t q[$];

  bit pageOpen, pageWr, refPend, rspDue, hsSeen;
  logic [7:0] rowM, colM, refRowM;
  logic [3:0] rspDat;
  int cyc, refCountM, negCount = 0;

  function automatic pin_t mk(bit ras, bit cas, bit we, bit oe, logic [7:0] a,
                              logic [3:0] d, int tag);
    pin_t p;
    p.ras = ras; p.cas = cas; p.we = we; p.oe = oe; p.addr = a; p.dq = d;
    p.rsp = 0; p.rdat = '0; p.tag = tag;
    return p;
  endfunction

  task automatic pushOp(bit hitPath);
    pin_t p;
    colM = reqAddr[7:0];
    pageWr = reqWrite;
    if (reqWrite) begin
      expMem[reqAddr] = reqWdata;
      q.push_back(mk(0, 1, 0, 1, colM, reqWdata, 4));
      for (int i = 0; i < T_WP; i++) q.push_back(mk(0, 0, 0, 1, colM, reqWdata, 4));
    end else begin
      for (int i = 0; i < T_CAC; i++) begin
        p = mk(0, 0, 1, 0, colM, '0, hitPath ? 5 : 3);
        if (i == T_CAC - 1) begin p.rsp = 1; p.rdat = expMem[reqAddr]; end
        q.push_back(p);
      end
    end
  endtask

  always @(negedge clk) begin
    pin_t e;
    bit expReady, took, hit;
    negCount++;
    hsSeen = reqValid && reqReady;
    if (!rst_n) begin
      q.delete();
      pageOpen = 0; pageWr = 0; refPend = 0; rspDue = 0;
      rowM = '0; colM = '0; refRowM = '0; cyc = 0; refCountM = 0;
      if (negCount >= 2) begin
        chk(1, "reset rasN", 16'(dramRasN), 16'(1));
        chk(1, "reset casN", 16'(dramCasN), 16'(1));
        chk(1, "reset weN", 16'(dramWeN), 16'(1));
        chk(1, "reset dqOe", 16'(dramDqOe), 16'(0));
        chk(1, "reset rspValid", 16'(rspValid), 16'(0));
      end
    end else begin
      expReady = 0; took = 0;
      if (q.size() > 0) begin
        e = q.pop_front();
      end else if (!pageOpen) begin
        e = mk(1, 1, 1, 0, rowM, '0, 6);
        expReady = !refPend;
        if (refPend) begin
          took = 1;
          q.push_back(mk(1, 1, 1, 0, refRowM, '0, 7));
          for (int i = 0; i < T_REF_RAS; i++) q.push_back(mk(0, 1, 1, 0, refRowM, '0, 10));
          for (int i = 0; i < T_RP; i++) q.push_back(mk(1, 1, 1, 0, rowM, '0, 8));
          refRowM = refRowM + 8'd1;
          refCountM++;
        end else if (reqValid) begin
          rowM = reqAddr[15:8];
          q.push_back(mk(1, 1, 1, 0, rowM, '0, 2));
          for (int i = 0; i < T_RAH; i++) q.push_back(mk(0, 1, 1, 0, rowM, '0, 2));
          pushOp(0);
          pageOpen = 1;
        end
      end else begin
        e = mk(0, pageWr, 1, 0, colM, '0, 5);
        hit = (reqAddr[15:8] == rowM) && (reqWrite == pageWr);
        expReady = !refPend && reqValid && hit;
        if (refPend) begin
          for (int i = 0; i < T_RP; i++) q.push_back(mk(1, 1, 1, 0, rowM, '0, 9));
          pageOpen = 0;
        end else if (reqValid) begin
          if (hit) pushOp(1);
          else begin
            for (int i = 0; i < T_RP; i++) q.push_back(mk(1, 1, 1, 0, rowM, '0, 6));
            pageOpen = 0;
          end
        end
      end

      chk(e.tag, "rasN", 16'(dramRasN), 16'(e.ras));
      chk(e.tag, "casN", 16'(dramCasN), 16'(e.cas));
      chk(e.tag, "weN", 16'(dramWeN), 16'(e.we));
      chk(e.tag, "address", 16'(dramA), 16'(e.addr));
      chk(11, "dqOe", 16'(dramDqOe), 16'(e.oe));
      if (e.oe) chk(4, "write data", 16'(dramDqOut), 16'(e.dq));
      chk(12, "reqReady", 16'(reqReady), 16'(expReady));
      chk(3, "rspValid", 16'(rspValid), 16'(rspDue));
      if (rspDue) chk(3, "rspData", 16'(rspData), 16'(rspDat));
      rspDue = e.rsp;
      rspDat = e.rdat;

      if (took) refPend = 0;
      if ((cyc % REF_PERIOD) == REF_PERIOD - 1) refPend = 1;
      cyc++;
    end
  end

  // Stimulus
  task automatic idleCycles(int n);
    reqValid = 0;
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic doReq(bit wr, logic [15:0] a, logic [3:0] d);
    reqValid = 1; reqWrite = wr; reqAddr = a; reqWdata = d;
    forever begin
      @(posedge clk); #1;
      if (hsSeen) break;
    end
    reqValid = 0;
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
  endtask

  initial begin
    logic [7:0] rows [4];
    rows[0] = 8'h12; rows[1] = 8'h34; rows[2] = 8'hFF; rows[3] = 8'h00;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R4 page-hit writes on one row
    for (int c = 0; c < 6; c++) doReq(1, {8'h12, 8'(c)}, 4'(c + 9));
    // R6 direction change, then R5 page-hit reads
    for (int c = 0; c < 6; c++) doReq(0, {8'h12, 8'(c)}, '0);
    // R6 row miss and direction miss
    doReq(0, 16'h3400, '0);
    doReq(1, 16'h3401, 4'hA);
    doReq(0, 16'h3401, '0);
    // R9 open page left idle until the refresh closes it
    idleCycles(120);
    // Mixed traffic
    for (int n = 0; n < 1500; n++) begin
      logic [15:0] a;
      a = {rows[$urandom_range(3, 0)], 8'($urandom_range(7, 0))};
      doReq(1'($urandom_range(1, 0)), a, 4'($urandom));
      idleCycles($urandom_range(2, 0));
    end
    // R10 make sure the refresh row has wrapped
    while (refCountM < 260) idleCycles(1);
    idleCycles(20);
    summary();
    finished = 1;
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFail++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end
endmodule